// File: doc/BRIEF.md
# Stepped-Duty PWM Engine

This block produces a fixed-period pulse-width waveform for a switched charge path. A phase counter advances on a clock-enable tick and spans `PERIOD` ticks. The output goes high when the counter is at its first phase. It goes low once the counter reaches the current high-time count. The high time therefore sets the duty cycle, from a single tick up to one tick short of the full period.

The duty cycle does not track an analog loop continuously. A slow pacer counts whole periods and raises a one-cycle update strobe once every `UPD_PERIODS` periods. An outside controller decides whether that strobe may move the duty cycle. When it may, a direction bit selects a one-tick step: shorter or longer. A preload control sets the duty cycle straight to its maximum, which is used when bulk charging begins. A freeze control holds the pacer at zero, so the duty cycle stays where it is.

The waveform is provided twice for the power switch: once in true polarity and once inverted, so that either gate sense can be driven. All control pins are plain levels or pulses sampled on the system clock. The block has no data stream, so there is no handshake at its boundary.

Top module: `stepduty_pwm`

## Requirements
- R1: While `rst_n` is low, the block is held in its initial state. In that state the high-time count equals `DUTY_MAX`, the phase and the pacer are at zero, `upd_strobe` is low, and `pwm_out` is high.
- R2: Each period spans `PERIOD` cycles in which `tick_en` is high. `pwm_out` is high from phase 0 up to the current high-time count, and low for the remaining ticks. It is always low in phase `PERIOD-1`.
- R3: In a cycle where `tick_en` is low, the phase does not advance and the pacer does not count. `pwm_out` is unchanged in the following cycle.
- R4: `upd_strobe` is a single-cycle pulse. It rises in the cycle after every `UPD_PERIODS`-th completed period, so consecutive strobes are `PERIOD*UPD_PERIODS` ticks apart.
- R5: A strobe taken while `upd_en` is high steps the high-time count by one tick. With `dir_down`=1 it shortens by one tick; with `dir_down`=0 it lengthens by one tick.
- R6: A strobe taken while `upd_en` is low leaves the duty cycle unchanged.
- R7: The high-time count saturates: it never goes below `DUTY_MIN` or above `DUTY_MAX`. A step past either limit leaves it at that limit.
- R8: A new high-time count takes effect only at a period boundary. A step taken in the first cycle of one period is therefore first seen in the period after that one.
- R9: While `upd_freeze` is high, the pacer is held at zero, no strobe is issued, and the duty cycle stays fixed.
- R10: A cycle with `preload_high` high sets the high-time count to `DUTY_MAX`. This takes precedence over a step in the same cycle, and the new value takes effect at the next period boundary.
- R11: `fet_drv` always equals `pwm_out`, and `fet_drv_n` is always its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | PWM tick enable (divided clock) |
| dir_down | input | 1 | Step direction: 1 shortens, 0 lengthens |
| upd_en | input | 1 | Lets the update strobe step the duty cycle |
| upd_freeze | input | 1 | Holds the update pacer in reset |
| preload_high | input | 1 | Sets the duty cycle to its maximum |
| pwm_out | output | 1 | PWM waveform |
| upd_strobe | output | 1 | One-cycle update strobe from the pacer |
| fet_drv | output | 1 | Switch drive, true polarity |
| fet_drv_n | output | 1 | Switch drive, inverted polarity |

## Verification
The bench builds the engine with `PERIOD`=8, `UPD_PERIODS`=3, `DUTY_MIN`=1 and `DUTY_MAX`=7. An update then arrives every 24 ticks rather than every 15 810. This lets a short run step the duty cycle from the top limit down into the lower limit and back. Along the way the run reaches both saturation points, the gated strobe, freeze and preload. Each duty value is measured as the number of high ticks between two rising edges of the output, so the one-period delay in applying a new count is checked directly.

// File: rtl/stepduty_pkg.sv
package stepduty_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_DOWN = 2'd1,
    ACT_UP   = 2'd2,
    ACT_LOAD = 2'd3
  } duty_act_e;
endpackage

// File: rtl/sd_phase_gen.sv
module sd_phase_gen #(
  parameter int PERIOD = 62,
  parameter int PH_W   = $clog2(PERIOD)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  output logic [PH_W-1:0] ph,
  output logic            wrap
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

  // wrap marks the final tick of a period
  assign wrap = tick_en && (ph == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)       ph <= '0;
    else if (wrap)    ph <= '0;
    else if (tick_en) ph <= ph + 1'b1;
  end
endmodule

// File: rtl/sd_upd_pacer.sv
module sd_upd_pacer #(
  parameter int UPD_PERIODS = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic freeze,
  output logic strobe
);
  localparam int CNT_W = (UPD_PERIODS > 1) ? $clog2(UPD_PERIODS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(UPD_PERIODS - 1);

  logic [CNT_W-1:0] cnt;
  logic             hit;

  assign hit = wrap && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || freeze) cnt <= '0;
    else if (hit)         cnt <= '0;
    else if (wrap)        cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) strobe <= 1'b0;
    else        strobe <= hit && !freeze;
  end
endmodule

// File: rtl/sd_duty_reg.sv
module sd_duty_reg
  import stepduty_pkg::*;
#(
  parameter int DUTY_MIN = 1,
  parameter int DUTY_MAX = 61,
  parameter int PH_W     = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  duty_act_e       action,
  input  logic            wrap,
  output logic [PH_W-1:0] duty_now
);
  localparam logic [PH_W-1:0] MINV = PH_W'(DUTY_MIN);
  localparam logic [PH_W-1:0] MAXV = PH_W'(DUTY_MAX);

  logic [PH_W-1:0] pend;
  logic [PH_W-1:0] pend_nxt;

  always_comb begin
    pend_nxt = pend;
    unique case (action)
      ACT_DOWN: if (pend > MINV) pend_nxt = pend - 1'b1;
      ACT_UP:   if (pend < MAXV) pend_nxt = pend + 1'b1;
      ACT_LOAD: pend_nxt = MAXV;
      default:  pend_nxt = pend;
    endcase
  end

  // pending value moves at once; the live count only at the boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= MAXV;
      duty_now <= MAXV;
    end else begin
      pend <= pend_nxt;
      if (wrap) duty_now <= pend_nxt;
    end
  end
endmodule

// File: rtl/stepduty_pwm.sv
module stepduty_pwm
  import stepduty_pkg::*;
#(
  parameter int PERIOD      = 62,
  parameter int UPD_PERIODS = 255,
  parameter int DUTY_MIN    = 1,
  parameter int DUTY_MAX    = PERIOD - 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic dir_down,
  input  logic upd_en,
  input  logic upd_freeze,
  input  logic preload_high,
  output logic pwm_out,
  output logic upd_strobe,
  output logic fet_drv,
  output logic fet_drv_n
);
  localparam int PH_W = $clog2(PERIOD);

  logic [PH_W-1:0] ph;
  logic            wrap;
  logic [PH_W-1:0] duty_now;
  duty_act_e       action;

  sd_phase_gen #(.PERIOD(PERIOD), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ph(ph), .wrap(wrap)
  );

  sd_upd_pacer #(.UPD_PERIODS(UPD_PERIODS)) u_pacer (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .freeze(upd_freeze),
    .strobe(upd_strobe)
  );

  always_comb begin
    if (preload_high)              action = ACT_LOAD;
    else if (upd_strobe && upd_en) action = dir_down ? ACT_DOWN : ACT_UP;
    else                           action = ACT_HOLD;
  end

  sd_duty_reg #(.DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX), .PH_W(PH_W)) u_duty (
    .clk(clk), .rst_n(rst_n), .action(action), .wrap(wrap),
    .duty_now(duty_now)
  );

  // set at phase 0, cleared when the phase reaches the high-time count
  assign pwm_out   = (ph < duty_now);
  assign fet_drv   = pwm_out;
  assign fet_drv_n = ~pwm_out;
endmodule

// File: rtl/sd_pwm_chk.sv
module sd_pwm_chk #(
  parameter int PERIOD   = 62,
  parameter int DUTY_MIN = 1,
  parameter int DUTY_MAX = 61,
  parameter int PH_W     = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick_en,
  input logic            upd_freeze,
  input logic            upd_strobe,
  input logic            pwm_out,
  input logic            wrap,
  input logic [PH_W-1:0] ph,
  input logic [PH_W-1:0] duty_now
);
  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |=> !upd_strobe);

  // R9
  freeze_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_freeze |=> !upd_strobe);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(pwm_out));

  // R8
  boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_now));

  // R7
  duty_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(duty_now) >= DUTY_MIN) && (int'(duty_now) <= DUTY_MAX));

  // R2
  tail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_W'(PERIOD - 1)) |-> !pwm_out);
endmodule

bind stepduty_pwm sd_pwm_chk #(
  .PERIOD(PERIOD), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX), .PH_W(PH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .upd_freeze(upd_freeze),
  .upd_strobe(upd_strobe), .pwm_out(pwm_out), .wrap(wrap), .ph(ph),
  .duty_now(duty_now)
);

// File: tb/sim_stepduty_pwm.sv
module sim_stepduty_pwm;
  localparam int PERIOD = 8;
  localparam int UPD    = 3;
  localparam int DMIN   = 1;
  localparam int DMAX   = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1;
  logic dir_down = 1'b0;
  logic upd_en = 1'b0;
  logic upd_freeze = 1'b0;
  logic preload_high = 1'b0;
  logic pwm_out, upd_strobe, fet_drv, fet_drv_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stepduty_pwm #(.PERIOD(PERIOD), .UPD_PERIODS(UPD), .DUTY_MIN(DMIN),
                 .DUTY_MAX(DMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dir_down(dir_down),
    .upd_en(upd_en), .upd_freeze(upd_freeze), .preload_high(preload_high),
    .pwm_out(pwm_out), .upd_strobe(upd_strobe), .fet_drv(fet_drv),
    .fet_drv_n(fet_drv_n)
  );

  // bit5 dir_down, bit4 upd_en, bits3:0 expected high ticks
  localparam logic [5:0] VEC [0:11] = '{
    6'b11_0110, 6'b11_0101, 6'b01_0110, 6'b10_0110,
    6'b11_0101, 6'b11_0100, 6'b11_0011, 6'b11_0010,
    6'b11_0001, 6'b11_0001, 6'b01_0010, 6'b00_0010
  };

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!upd_strobe);
  endtask

  // counts high ticks over one period, starting at a rising edge
  task automatic measure(output int hi);
    int fbad;
    hi = 0;
    fbad = 0;
    while (pwm_out !== 1'b0) @(negedge clk);
    while (pwm_out !== 1'b1) @(negedge clk);
    for (int i = 0; i < PERIOD; i++) begin
      if (pwm_out) hi++;
      if (fet_drv !== pwm_out || fet_drv_n !== ~pwm_out) fbad++;
      @(negedge clk);
    end
    chk("R11 drive polarity", fbad, 0);
  endtask

  initial begin
    int hi;
    int gap;
    int seen;
    logic held;
    repeat (3) @(negedge clk);
    // R1 state during reset
    chk("R1 pwm", int'(pwm_out), 1);
    chk("R1 strobe", int'(upd_strobe), 0);
    chk("R1 fet_n", int'(fet_drv_n), 0);
    rst_n = 1'b1;
    measure(hi);
    chk("R1 initial duty", hi, DMAX);

    // R4 strobe spacing
    wait_strobe();
    gap = 0;
    do begin @(negedge clk); gap++; end while (!upd_strobe);
    chk("R4 strobe spacing", gap, PERIOD * UPD);
    @(negedge clk);
    chk("R4 strobe width", int'(upd_strobe), 0);

    // table of steps: R5, R6, R7 lower limit, R8 one-period delay
    for (int v = 0; v < 12; v++) begin
      dir_down = VEC[v][5];
      upd_en   = VEC[v][4];
      wait_strobe();
      measure(hi);
      if (v == 9)          chk("R7 lower saturation", hi, int'(VEC[v][3:0]));
      else if (!VEC[v][4]) chk("R6 gated strobe", hi, int'(VEC[v][3:0]));
      else                 chk("R5 R8 step", hi, int'(VEC[v][3:0]));
    end
    upd_en = 1'b0;

    // R3 stalled tick
    @(negedge clk);
    tick_en = 1'b0;
    held = pwm_out;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_out !== held || upd_strobe) seen++;
    end
    chk("R3 stall holds", seen, 0);
    tick_en = 1'b1;
    measure(hi);
    chk("R3 duty after stall", hi, 2);

    // R9 freeze
    upd_freeze = 1'b1;
    upd_en = 1'b1;
    dir_down = 1'b1;
    seen = 0;
    for (int i = 0; i < 5 * PERIOD * UPD; i++) begin
      @(negedge clk);
      if (upd_strobe) seen++;
    end
    chk("R9 no strobe", seen, 0);
    measure(hi);
    chk("R9 duty fixed", hi, 2);
    upd_en = 1'b0;
    upd_freeze = 1'b0;

    // R10 preload
    @(negedge clk);
    preload_high = 1'b1;
    @(negedge clk);
    preload_high = 1'b0;
    measure(hi);
    chk("R10 preload", hi, DMAX);

    // R7 upper limit
    upd_en = 1'b1;
    dir_down = 1'b0;
    wait_strobe();
    measure(hi);
    chk("R7 upper saturation", hi, DMAX);
    upd_en = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule